// File: doc/BRIEF.md
# Two-Instruction Single-Cycle Processor Core

This block is a 32-bit processor that completes one instruction on every clock edge. It knows two operations. The first adds a sign-extended 12-bit constant to a register. The second is a conditional branch that jumps by a signed offset when two registers differ. Every other opcode is treated as a no-op. The core holds a program counter, an instruction store that is read without a clock, a decoder, an immediate builder, a 32-entry register file and an adder/subtractor.

A host fills the instruction store through a write port before it releases reset. After that the core runs freely. The value of register 10 is driven onto a dedicated output at all times, so a program leaves its result there for observation.

Top module: `sc_core`

## Requirements
- R1: While reset is active, and on the first edge after release, the program counter is 0 and all 32 registers are 0. Registers written by an earlier run read 0 after a new reset.
- R2: Opcode bits [6:0] = 7'b0010011 adds. Register rd (bits [11:7]) receives rs1 (bits [19:15]) plus bits [31:20] sign-extended. Bits [14:12] do not affect the result, and the program counter advances by 4.
- R3: Opcode 7'b1100011 with bits [14:12] = 3'b001 and rs1 != rs2 (rs2 in bits [24:20]) sets the program counter to PC plus the offset {b31, b7, b30..b25, b11..b8, 0}, sign-extended from 13 bits. Backward offsets are included.
- R4: A branch opcode whose registers are equal, or whose bits [14:12] are not 3'b001, advances the program counter by 4. No branch ever writes a register.
- R5: Writes that target register 0 are dropped, and register 0 always reads 0.
- R6: Any other opcode writes no register and advances the program counter by 4. An all-zero word is such a no-op.
- R7: `obs_value` always shows register 10. It updates right after the edge that writes that register.
- R8: The instruction at word address PC[9:2] is read combinationally (depth 2^IMEM_AW, default 256 words). The load port writes `load_data` at `load_addr` on a rising edge while `load_we` is 1.
- R9: Driving `rst_n` low clears the state at once, with no clock. After release, the first instruction completes on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| load_we | input | 1 | Instruction store write enable |
| load_addr | input | IMEM_AW | Word address for the load port |
| load_data | input | 32 | Instruction word to store |
| obs_value | output | 32 | Current contents of register 10 |

## Verification
The embedded properties assume two things. The instruction store is written only while the core is held in reset. The words it holds are defined, either written or zero-filled, so the decoded controls are never unknown. The bench zero-fills every word and loads each program with `rst_n` low before it releases the core. Assertions that compare the program counter across cycles depend on a stable instruction word within each cycle. The bench therefore never touches the load port while the core runs.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN   = 32;
  localparam int ILEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_ADDI   = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [2:0] F3_NE      = 3'b001;

  typedef struct packed {
    logic rf_we;
    logic op2_imm;
    logic is_branch;
    logic alu_add;
    logic br_ne;
  } ctrl_t;
endpackage

// File: rtl/sc_imem.sv
module sc_imem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [ILEN-1:0]   instr,
  output ctrl_t             ctrl,
  output logic [XLEN-1:0]   imm,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd
);
  localparam int IW_I = 12;
  localparam int IW_B = 13;

  logic [6:0]      opcode;
  logic [2:0]      funct3;
  logic [IW_I-1:0] raw_i;
  logic [IW_B-1:0] raw_b;
  logic            imm_btype;

  assign opcode = instr[6:0];
  assign funct3 = instr[14:12];
  assign rd     = instr[11:7];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];

  assign raw_i = instr[31:20];
  assign raw_b = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};

  always_comb begin
    ctrl      = '0;
    ctrl.alu_add = 1'b1;
    imm_btype = 1'b0;
    case (opcode)
      OPC_ADDI: begin
        ctrl.rf_we   = 1'b1;
        ctrl.op2_imm = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_add   = 1'b0;
        ctrl.br_ne     = (funct3 == F3_NE);
        imm_btype      = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_comb begin
    if (imm_btype) begin
      imm = {{(XLEN-IW_B){raw_b[IW_B-1]}}, raw_b};
    end else begin
      imm = {{(XLEN-IW_I){raw_i[IW_I-1]}}, raw_i};
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          do_add,
  output logic [DW-1:0] res,
  output logic          differ
);
  logic [DW-1:0] sum;
  logic [DW-1:0] diff;

  assign sum    = op_a + op_b;
  assign diff   = op_a - op_b;
  assign differ = (diff != '0);

  always_comb begin
    if (do_add) begin
      res = sum;
    end else begin
      res = diff;
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_core_pkg::*;
#(
  parameter int AW      = REG_AW,
  parameter int DW      = XLEN,
  parameter int OBS_IDX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] obs
);
  localparam int N = 1 << AW;

  logic [DW-1:0] regs_q [N];
  logic [N-1:0]  wen;

  always_comb begin
    wen = '0;
    if (we && (wa != '0)) begin
      wen[wa] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wen[i]) begin
          regs_q[i] <= wd;
        end
      end
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign obs     = regs_q[OBS_IDX];

  a_r5_x0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == '0) |-> (ra_data == '0));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd)));

  a_r7_obs_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa == AW'(OBS_IDX))) |=> (obs == $past(wd)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int OBS_REG = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_we,
  input  logic [IMEM_AW-1:0] load_addr,
  input  logic [ILEN-1:0]    load_data,
  output logic [XLEN-1:0]    obs_value
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_d;
  logic [ILEN-1:0]   instr;
  ctrl_t             ctrl;
  logic [XLEN-1:0]   imm;
  logic [REG_AW-1:0] rs1;
  logic [REG_AW-1:0] rs2;
  logic [REG_AW-1:0] rd;
  logic [XLEN-1:0]   rs1_data;
  logic [XLEN-1:0]   rs2_data;
  logic [XLEN-1:0]   op_b;
  logic [XLEN-1:0]   alu_res;
  logic              alu_differ;
  logic              br_taken;

  // reset: asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  sc_imem #(.AW(IMEM_AW), .DW(ILEN)) u_imem (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  sc_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl),
    .imm   (imm),
    .rs1   (rs1),
    .rs2   (rs2),
    .rd    (rd)
  );

  sc_regfile #(.AW(REG_AW), .DW(XLEN), .OBS_IDX(OBS_REG)) u_rf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .ra_addr (rs1),
    .ra_data (rs1_data),
    .rb_addr (rs2),
    .rb_data (rs2_data),
    .we      (ctrl.rf_we),
    .wa      (rd),
    .wd      (alu_res),
    .obs     (obs_value)
  );

  assign op_b = ctrl.op2_imm ? imm : rs2_data;

  sc_alu #(.DW(XLEN)) u_alu (
    .op_a   (rs1_data),
    .op_b   (op_b),
    .do_add (ctrl.alu_add),
    .res    (alu_res),
    .differ (alu_differ)
  );

  assign br_taken = ctrl.is_branch & ctrl.br_ne & alu_differ;

  always_comb begin
    if (br_taken) begin
      pc_d = pc_q + imm;
    end else begin
      pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  a_r1_pc_from_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (pc_q == '0));

  a_r3_branch_target: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> (pc_q == $past(pc_q) + $past(imm)));

  a_r4_seq_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    !br_taken |=> (pc_q == $past(pc_q) + STEP));

  a_r4_branch_no_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl.is_branch |-> !ctrl.rf_we);

  a_r6_unknown_inert: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((instr[6:0] != OPC_ADDI) && (instr[6:0] != OPC_BRANCH))
      |-> (!ctrl.rf_we && !ctrl.is_branch));
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int AW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_we;
  logic [AW-1:0] load_addr;
  logic [31:0]   load_data;
  logic [31:0]   obs_value;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sc_core #(.IMEM_AW(AW), .OBS_REG(10)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data),
    .obs_value (obs_value)
  );

  // vector table: kind 0 = add-imm, 1 = branch, 2 = unknown opcode
  localparam int T_KIND [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 2, 0, 0};
  localparam int T_RD   [NV] = '{10, 10, 0, 10, 11, 0, 10, 0, 10, 10, 10, 10};
  localparam int T_RS1  [NV] = '{0, 10, 10, 0, 0, 10, 10, 10, 10, 10, 10, 10};
  localparam int T_RS2  [NV] = '{0, 0, 0, 0, 0, 11, 0, 11, 0, 10, 0, 0};
  localparam int T_F3   [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 7, 0};
  localparam int T_IMM  [NV] = '{5, -7, 100, 3, 3, 8, 1, 8, 1, 0, 2047, -2048};
  localparam int T_EXP  [NV] = '{5, -2, -2, 3, 3, 3, 4, 4, 5, 5, 2052, 4};
  // R2 rows 0,1,10,11; R5 rows 2,3; R4 rows 5..8; R6 row 9; R9 row 0 timing
  localparam string T_REQ [NV] = '{"R2/R9", "R2", "R5", "R5", "R2", "R4",
                                   "R4", "R4", "R4", "R6", "R2", "R2"};

  function automatic logic [31:0] enc_i(int rd, int rs1, int imm, int f3);
    logic [11:0] i12;
    i12 = imm[11:0];
    return {i12, rs1[4:0], f3[2:0], rd[4:0], 7'b0010011};
  endfunction

  function automatic logic [31:0] enc_b(int f3, int rs1, int rs2, int imm);
    logic [12:0] b;
    b = imm[12:0];
    return {b[12], b[10:5], rs2[4:0], rs1[4:0], f3[2:0], b[4:1], b[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_row(int i);
    case (T_KIND[i])
      0:       return enc_i(T_RD[i], T_RS1[i], T_IMM[i], T_F3[i]);
      1:       return enc_b(T_F3[i], T_RS1[i], T_RS2[i], T_IMM[i]);
      default: return {7'd0, T_RS2[i][4:0], T_RS1[i][4:0], 3'd0, T_RD[i][4:0], 7'b0110011};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: obs_value actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int addr, input logic [31:0] word);
    @(negedge clk);
    load_we   = 1'b1;
    load_addr = addr[AW-1:0];
    load_data = word;
    @(negedge clk);
    load_we   = 1'b0;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual run still busy expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    load_we   = 1'b0;
    load_addr = '0;
    load_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", obs_value, 32'd0);

    for (int a = 0; a < (1 << AW); a++) load(a, 32'd0);
    for (int i = 0; i < NV; i++) load(i, enc_row(i));
    // R3 forward taken: skip word 13
    load(12, enc_b(1, 10, 11, 8));
    load(13, enc_i(10, 0, 99, 0));
    load(14, enc_i(10, 10, 10, 0));
    // R3 backward loop: 4 passes of +3
    load(15, enc_i(5, 0, 4, 0));
    load(16, enc_i(10, 0, 0, 0));
    load(17, enc_i(10, 10, 3, 0));
    load(18, enc_i(5, 5, -1, 0));
    load(19, enc_b(1, 5, 0, -8));
    load(20, enc_i(10, 10, 100, 0));

    release_reset();
    @(negedge clk);
    check("R9", obs_value, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(1);
      check(T_REQ[i], obs_value, 32'(T_EXP[i]));
    end

    step(1);
    check("R3", obs_value, 32'd4);
    step(1);
    check("R3", obs_value, 32'd14);
    step(2);
    check("R7", obs_value, 32'd0);
    step(12);
    check("R3", obs_value, 32'd12);
    step(1);
    check("R3", obs_value, 32'd112);
    step(4);
    check("R6", obs_value, 32'd112);

    // R9 asynchronous clear, no clock edge needed
    #5;
    rst_n = 1'b0;
    #1;
    check("R9", obs_value, 32'd0);

    // R1 registers cleared: x11 held 3 before reset
    load(0, enc_i(10, 11, 0, 0));
    load(1, enc_i(10, 10, 7, 0));
    check("R8", obs_value, 32'd0);
    release_reset();
    @(negedge clk);
    check("R1", obs_value, 32'd0);
    step(1);
    check("R1", obs_value, 32'd0);
    step(1);
    check("R8", obs_value, 32'd7);

    summary();
    $finish;
  end
endmodule